// File: doc/BRIEF.md
# Day and Seconds-of-Day Real-Time Counter with Alarm

This block keeps wall-clock time as two counts: a day number and the seconds elapsed within that day. A one-cycle pulse on `tick`, one per second and produced outside the block, advances the time. The seconds-of-day count is 17 bits wide and is split across two registers: an 8-bit low byte and a 9-bit high field. Its value is `low + (high << 8)`. The day count sits beside it in a 15-bit register.

Software reads and writes the time through a small word port. The same port gives access to a matching three-register alarm time, an interrupt enable register and a sticky interrupt status register. The block drives two level interrupt outputs. One is raised when the running time reaches the alarm time. The other is raised on every second tick. Each output has its own enable bit.

A carry from the low byte into the high field happens only every 256 seconds. Software can therefore set the time without tearing. It first writes 0 to the low byte, then writes the day, then the high field, and finally the low byte. The new time is complete at the last write.

Top module: `rtc_dayclock`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads 0, and both `irq_alarm` and `irq_update` are 0.
- R2: The register addresses are as follows. Time is at 0 (low byte), 1 (high field) and 2 (day). The alarm is at 3 (low byte), 4 (high field) and 5 (day). Interrupt enable is at 6 and interrupt status is at 7. A tick with no time-register write in the same cycle increments seconds-of-day (`low + high*256`) by one. When the low byte passes 255 it returns to 0 and the high field increments.
- R3: A tick taken when seconds-of-day equals 86399 (high 0x151, low 0x7F) sets seconds-of-day to 0 and increments the day. The day count wraps from 0x7FFF to 0.
- R4: Writes keep only the implemented bits: 8 bits for the low bytes, 9 bits for the high fields, 15 bits for the days and 2 bits for enable and status. Unused upper bits of every register read as 0.
- R5: Every tick sets status bit 1 (update). `irq_update` is high while status bit 1 and enable bit 1 are both set. It rises in the cycle after the tick edge.
- R6: Status bit 0 (alarm) is set one cycle after the time first becomes equal to the alarm time in day, high and low. It is set again only after the two have differed. The all-zero state after reset does not count as a new match. `irq_alarm` is high while status bit 0 and enable bit 0 are both set.
- R7: When a source's enable bit is 0, that source's interrupt output stays low, but its status bit is still set and can be read.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the bit ends up set.
- R9: A tick in the same cycle as a write to any time register (addresses 0 to 2) does not advance the time. The written register takes the written value and the other registers hold. The tick still sets status bit 1.
- R10: After the low byte is written with 0, the high field does not change for the next 255 ticks. The sequence (low = 0, day, high, low) leaves exactly the written time, even with ticks between the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_update | output | 1 | Once-per-second interrupt, level |

## Verification
Register writes and tick counts appear on `reg_rdata` right after the clock edge that takes them. The read is combinational, so every check samples two nanoseconds after the edge of its own stimulus cycle. `irq_update` follows a tick after the same single edge. `irq_alarm` needs one more edge past the edge that makes the times equal. The bench checks that the output is still low right after the equal edge and high after the next one. In the random phase a cycle-by-cycle reference model gives the expected values, and every output is compared once per cycle at that same post-edge point.

// File: rtl/rtc_dayclock_pkg.sv
package rtc_dayclock_pkg;
   typedef enum logic [2:0] {
      RA_TLO   = 3'd0,
      RA_THI   = 3'd1,
      RA_TDAY  = 3'd2,
      RA_ALO   = 3'd3,
      RA_AHI   = 3'd4,
      RA_ADAY  = 3'd5,
      RA_IEN   = 3'd6,
      RA_ISTAT = 3'd7
   } rtc_reg_e;

   localparam int unsigned SRC_ALARM  = 0;
   localparam int unsigned SRC_UPDATE = 1;
   localparam int unsigned NUM_SRC    = 2;
endpackage

// File: rtl/rtc_sod_counter.sv
module rtc_sod_counter #(
   parameter int unsigned LO_W         = 8,
   parameter int unsigned HI_W         = 9,
   parameter int unsigned SECS_PER_DAY = 86400
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [LO_W-1:0] lo_in,
   input  logic [HI_W-1:0] hi_in,
   output logic [LO_W-1:0] lo,
   output logic [HI_W-1:0] hi,
   output logic            day_carry
);
   localparam int unsigned SOD_W = LO_W + HI_W;
   localparam logic [SOD_W-1:0] SOD_LAST = SOD_W'(SECS_PER_DAY - 1);

   logic [SOD_W-1:0] sod;
   logic [SOD_W-1:0] sod_nxt;
   logic             at_last;

   assign sod       = {hi, lo};
   assign at_last   = (sod == SOD_LAST);
   assign day_carry = adv & at_last;
   assign sod_nxt   = at_last ? '0 : sod + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         if (wr_lo)    lo <= lo_in;
         else if (adv) lo <= sod_nxt[LO_W-1:0];
         if (wr_hi)    hi <= hi_in;
         else if (adv) hi <= sod_nxt[SOD_W-1:LO_W];
      end
   end
endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
   parameter int unsigned DAY_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [DAY_W-1:0] din,
   input  logic             inc,
   output logic [DAY_W-1:0] day
);
   always_ff @(posedge clk) begin
      if (!rst_n)   day <= '0;
      else if (wr)  day <= din;
      else if (inc) day <= day + 1'b1;
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] alm,
   output logic         hit
);
   logic eq;
   logic eq_q;

   assign eq  = (cur == alm);
   assign hit = eq & ~eq_q;

   // Reset state counts as already matched: all-zero time equals all-zero alarm.
   always_ff @(posedge clk) begin
      if (!rst_n) eq_q <= 1'b1;
      else        eq_q <= eq;
   end
endmodule

// File: rtl/rtc_irq_src.sv
module rtc_irq_src (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & en;
endmodule

// File: rtl/rtc_dayclock.sv
module rtc_dayclock
   import rtc_dayclock_pkg::*;
#(
   parameter int unsigned LO_W         = 8,
   parameter int unsigned HI_W         = 9,
   parameter int unsigned DAY_W        = 15,
   parameter int unsigned SECS_PER_DAY = 86400,
   parameter int unsigned DATA_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_alarm,
   output logic              irq_update
);
   localparam int unsigned SOD_W  = LO_W + HI_W;
   localparam int unsigned TIME_W = DAY_W + SOD_W;

   if (SECS_PER_DAY < 2 || SECS_PER_DAY > (2 ** SOD_W)) begin : g_bad_sod
      $error("rtc_dayclock: seconds-of-day does not fit LO_W+HI_W bits");
   end
   if (DATA_W < LO_W || DATA_W < HI_W || DATA_W < DAY_W || DATA_W < NUM_SRC) begin : g_bad_data
      $error("rtc_dayclock: DATA_W narrower than a register field");
   end

   rtc_reg_e addr;
   assign addr = rtc_reg_e'(reg_addr);

   logic wr_tlo, wr_thi, wr_tday, wr_alo, wr_ahi, wr_aday, wr_ien, wr_stat;
   assign wr_tlo  = reg_we && (addr == RA_TLO);
   assign wr_thi  = reg_we && (addr == RA_THI);
   assign wr_tday = reg_we && (addr == RA_TDAY);
   assign wr_alo  = reg_we && (addr == RA_ALO);
   assign wr_ahi  = reg_we && (addr == RA_AHI);
   assign wr_aday = reg_we && (addr == RA_ADAY);
   assign wr_ien  = reg_we && (addr == RA_IEN);
   assign wr_stat = reg_we && (addr == RA_ISTAT);

   logic time_wr;
   logic adv;
   assign time_wr = wr_tlo | wr_thi | wr_tday;
   assign adv     = tick & ~time_wr;

   logic [LO_W-1:0]  t_lo;
   logic [HI_W-1:0]  t_hi;
   logic [DAY_W-1:0] t_day;
   logic             day_carry;

   rtc_sod_counter #(.LO_W(LO_W), .HI_W(HI_W), .SECS_PER_DAY(SECS_PER_DAY)) u_sod (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .wr_lo     (wr_tlo),
      .wr_hi     (wr_thi),
      .lo_in     (reg_wdata[LO_W-1:0]),
      .hi_in     (reg_wdata[HI_W-1:0]),
      .lo        (t_lo),
      .hi        (t_hi),
      .day_carry (day_carry)
   );

   rtc_day_counter #(.DAY_W(DAY_W)) u_day (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_tday),
      .din   (reg_wdata[DAY_W-1:0]),
      .inc   (day_carry),
      .day   (t_day)
   );

   logic [LO_W-1:0]    a_lo;
   logic [HI_W-1:0]    a_hi;
   logic [DAY_W-1:0]   a_day;
   logic [NUM_SRC-1:0] irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_lo   <= '0;
         a_hi   <= '0;
         a_day  <= '0;
         irq_en <= '0;
      end else begin
         if (wr_alo)  a_lo   <= reg_wdata[LO_W-1:0];
         if (wr_ahi)  a_hi   <= reg_wdata[HI_W-1:0];
         if (wr_aday) a_day  <= reg_wdata[DAY_W-1:0];
         if (wr_ien)  irq_en <= reg_wdata[NUM_SRC-1:0];
      end
   end

   logic alm_hit;
   rtc_alarm_match #(.W(TIME_W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   ({t_day, t_hi, t_lo}),
      .alm   ({a_day, a_hi, a_lo}),
      .hit   (alm_hit)
   );

   logic [NUM_SRC-1:0] src_set;
   logic [NUM_SRC-1:0] src_clr;
   logic [NUM_SRC-1:0] irq_flag;
   logic [NUM_SRC-1:0] irq_vec;

   always_comb begin
      src_set             = '0;
      src_set[SRC_ALARM]  = alm_hit;
      src_set[SRC_UPDATE] = tick;
   end
   assign src_clr = wr_stat ? reg_wdata[NUM_SRC-1:0] : '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      rtc_irq_src u_src (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (src_set[g]),
         .clr   (src_clr[g]),
         .en    (irq_en[g]),
         .flag  (irq_flag[g]),
         .irq   (irq_vec[g])
      );
   end

   assign irq_alarm  = irq_vec[SRC_ALARM];
   assign irq_update = irq_vec[SRC_UPDATE];

   always_comb begin
      reg_rdata = '0;
      case (addr)
         RA_TLO:   reg_rdata[LO_W-1:0]    = t_lo;
         RA_THI:   reg_rdata[HI_W-1:0]    = t_hi;
         RA_TDAY:  reg_rdata[DAY_W-1:0]   = t_day;
         RA_ALO:   reg_rdata[LO_W-1:0]    = a_lo;
         RA_AHI:   reg_rdata[HI_W-1:0]    = a_hi;
         RA_ADAY:  reg_rdata[DAY_W-1:0]   = a_day;
         RA_IEN:   reg_rdata[NUM_SRC-1:0] = irq_en;
         RA_ISTAT: reg_rdata[NUM_SRC-1:0] = irq_flag;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_dayclock_chk.sv
module rtc_dayclock_chk #(
   parameter int unsigned LO_W         = 8,
   parameter int unsigned HI_W         = 9,
   parameter int unsigned DAY_W        = 15,
   parameter int unsigned SECS_PER_DAY = 86400,
   parameter int unsigned DATA_W       = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [LO_W-1:0]   t_lo,
   input logic [HI_W-1:0]   t_hi,
   input logic [DAY_W-1:0]  t_day,
   input logic [LO_W-1:0]   a_lo,
   input logic [HI_W-1:0]   a_hi,
   input logic [DAY_W-1:0]  a_day,
   input logic [1:0]        irq_flag
);
   localparam int unsigned SOD_W = LO_W + HI_W;
   localparam logic [SOD_W-1:0] SOD_LAST = SOD_W'(SECS_PER_DAY - 1);

   logic twr, last, eq, clr_upd;
   assign twr     = reg_we && (reg_addr <= 3'd2);
   assign last    = ({t_hi, t_lo} == SOD_LAST);
   assign eq      = ({t_day, t_hi, t_lo} == {a_day, a_hi, a_lo});
   assign clr_upd = reg_we && (reg_addr == 3'd7) && reg_wdata[1];

   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !twr && !last) |=>
         ({t_hi, t_lo} == SOD_W'($past({t_hi, t_lo}) + 1'b1)) && $stable(t_day));

   a_r3_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !twr && last) |=>
         ({t_hi, t_lo} == '0) && (t_day == DAY_W'($past(t_day) + 1'b1)));

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0) |=> (t_lo == $past(reg_wdata[LO_W-1:0])));

   a_r5_update_set: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> irq_flag[1]);

   a_r6_alarm_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eq) |=> irq_flag[0]);

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[1] && !clr_upd) |=> irq_flag[1]);
endmodule

bind rtc_dayclock rtc_dayclock_chk #(
   .LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W),
   .SECS_PER_DAY(SECS_PER_DAY), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .t_lo      (t_lo),
   .t_hi      (t_hi),
   .t_day     (t_day),
   .a_lo      (a_lo),
   .a_hi      (a_hi),
   .a_day     (a_day),
   .irq_flag  (irq_flag)
);

// File: tb/rtc_dayclock_bench.sv
module rtc_dayclock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_alarm, irq_update;

   always #4 clk = ~clk;

   rtc_dayclock u_rtc_dayclock (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_alarm  (irq_alarm),
      .irq_update (irq_update)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Reference model state
   logic [7:0]  m_lo, m_alo;
   logic [8:0]  m_hi, m_ahi;
   logic [14:0] m_day, m_aday;
   logic [1:0]  m_en, m_flag;
   logic        m_mq;

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_reg(input logic [2:0] a);
      case (a)
         3'd0: return {8'h0, m_lo};
         3'd1: return {7'h0, m_hi};
         3'd2: return {1'b0, m_day};
         3'd3: return {8'h0, m_alo};
         3'd4: return {7'h0, m_ahi};
         3'd5: return {1'b0, m_aday};
         3'd6: return {14'h0, m_en};
         default: return {14'h0, m_flag};
      endcase
   endfunction

   task automatic step(input bit we, input logic [2:0] a, input logic [15:0] wd, input bit tk);
      logic        eq;
      logic [1:0]  clr;
      logic [16:0] sod;
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = wd; tick = tk;
      @(posedge clk);
      eq   = ({m_day, m_hi, m_lo} == {m_aday, m_ahi, m_alo});
      clr  = (we && a == 3'd7) ? wd[1:0] : 2'b00;
      m_flag = (m_flag & ~clr) | {tk, eq & ~m_mq};
      m_mq = eq;
      if (we) begin
         case (a)
            3'd0: m_lo   = wd[7:0];
            3'd1: m_hi   = wd[8:0];
            3'd2: m_day  = wd[14:0];
            3'd3: m_alo  = wd[7:0];
            3'd4: m_ahi  = wd[8:0];
            3'd5: m_aday = wd[14:0];
            3'd6: m_en   = wd[1:0];
            default: ;
         endcase
      end
      if (tk && !(we && a <= 3'd2)) begin
         sod = {m_hi, m_lo};
         if (sod == 17'd86399) begin
            {m_hi, m_lo} = '0;
            m_day = m_day + 1'b1;
         end else begin
            {m_hi, m_lo} = sod + 1'b1;
         end
      end
      #2;
      check("R6 irq_alarm vs model", int'(irq_alarm), int'(m_flag[0] & m_en[0]));
      check("R5 irq_update vs model", int'(irq_update), int'(m_flag[1] & m_en[1]));
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      step(1'b0, a, 16'h0, 1'b0);
      check(tag, int'(reg_rdata), int'(exp));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 run hung: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m_lo = 0; m_hi = 0; m_day = 0; m_alo = 0; m_ahi = 0; m_aday = 0;
      m_en = 0; m_flag = 0; m_mq = 1'b1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) rd(3'(a), 16'h0, "R1 reset register value");
      check("R1 irq_alarm after reset", int'(irq_alarm), 0);
      check("R1 irq_update after reset", int'(irq_update), 0);
      // R6: reset equality does not raise the alarm flag
      rd(3'd7, 16'h0, "R6 no alarm from reset match");

      // R4: field widths
      for (int a = 0; a < 6; a++) step(1'b1, 3'(a), 16'hFFFF, 1'b0);
      rd(3'd0, 16'h00FF, "R4 time low width");
      rd(3'd1, 16'h01FF, "R4 time high width");
      rd(3'd2, 16'h7FFF, "R4 day width");
      rd(3'd3, 16'h00FF, "R4 alarm low width");
      rd(3'd4, 16'h01FF, "R4 alarm high width");
      rd(3'd5, 16'h7FFF, "R4 alarm day width");
      step(1'b1, 3'd6, 16'hFFFF, 1'b0);
      rd(3'd6, 16'h0003, "R4 enable width");
      step(1'b1, 3'd6, 16'h0, 1'b0);
      step(1'b1, 3'd7, 16'h3, 1'b0);
      rd(3'd7, 16'h0, "R8 status cleared");

      // R2: count and carry into high field
      step(1'b1, 3'd1, 16'h0, 1'b0);
      step(1'b1, 3'd2, 16'h0, 1'b0);
      step(1'b1, 3'd0, 16'hFF, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd0, 16'h0, "R2 low wraps to 0");
      rd(3'd1, 16'h1, "R2 high increments on carry");
      step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd0, 16'h1, "R2 low increments");

      // R3: end of day and day wrap
      step(1'b1, 3'd2, 16'd5, 1'b0);
      step(1'b1, 3'd1, 16'h151, 1'b0);
      step(1'b1, 3'd0, 16'h7F, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd0, 16'h0, "R3 low after 86399");
      rd(3'd1, 16'h0, "R3 high after 86399");
      rd(3'd2, 16'd6, "R3 day incremented");
      step(1'b1, 3'd2, 16'h7FFF, 1'b0);
      step(1'b1, 3'd1, 16'h151, 1'b0);
      step(1'b1, 3'd0, 16'h7F, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd2, 16'h0, "R3 day wraps to 0");

      // R7: masked update source
      rd(3'd7, 16'h2, "R7 masked update flag still set");
      check("R7 masked irq_update low", int'(irq_update), 0);

      // R8: write-1-to-clear
      step(1'b1, 3'd7, 16'h1, 1'b0);
      rd(3'd7, 16'h2, "R8 writing 0 keeps bit");
      step(1'b1, 3'd7, 16'h2, 1'b0);
      rd(3'd7, 16'h0, "R8 writing 1 clears bit");

      // R5: update interrupt
      step(1'b1, 3'd6, 16'h2, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      check("R5 irq_update after tick", int'(irq_update), 1);
      step(1'b1, 3'd7, 16'h2, 1'b1);
      rd(3'd7, 16'h2, "R8 set wins over clear");
      step(1'b1, 3'd7, 16'h2, 1'b0);
      check("R8 irq_update cleared", int'(irq_update), 0);

      // R9: tick with time write
      step(1'b1, 3'd0, 16'd10, 1'b1);
      rd(3'd0, 16'd10, "R9 written low wins over tick");
      rd(3'd7, 16'h2, "R9 tick still sets update");
      step(1'b1, 3'd1, 16'd3, 1'b1);
      rd(3'd0, 16'd10, "R9 low holds on high write");
      rd(3'd1, 16'd3, "R9 high takes written value");
      step(1'b1, 3'd7, 16'h3, 1'b0);

      // R6: alarm timing
      step(1'b1, 3'd6, 16'h1, 1'b0);
      step(1'b1, 3'd3, 16'd102, 1'b0);
      step(1'b1, 3'd4, 16'd0, 1'b0);
      step(1'b1, 3'd5, 16'd2, 1'b0);
      step(1'b1, 3'd2, 16'd2, 1'b0);
      step(1'b1, 3'd1, 16'd0, 1'b0);
      step(1'b1, 3'd0, 16'd100, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      check("R6 irq_alarm not yet on equal edge", int'(irq_alarm), 0);
      step(1'b0, 3'd0, 16'h0, 1'b0);
      check("R6 irq_alarm one cycle later", int'(irq_alarm), 1);
      rd(3'd7, 16'h3, "R6 alarm status set");
      step(1'b1, 3'd7, 16'h3, 1'b0);

      // R10: tear-free set sequence
      step(1'b1, 3'd0, 16'h0, 1'b0);
      repeat (255) step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd1, 16'h0, "R10 high stable for 255 ticks");
      rd(3'd0, 16'hFF, "R10 low after 255 ticks");
      step(1'b1, 3'd0, 16'h0, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      step(1'b1, 3'd2, 16'd9, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      step(1'b1, 3'd1, 16'h100, 1'b0);
      step(1'b0, 3'd0, 16'h0, 1'b1);
      step(1'b1, 3'd0, 16'h20, 1'b0);
      rd(3'd0, 16'h20, "R10 low exact");
      rd(3'd1, 16'h100, "R10 high exact");
      rd(3'd2, 16'd9, "R10 day exact");
      step(1'b0, 3'd0, 16'h0, 1'b1);
      rd(3'd0, 16'h21, "R10 counts from set time");

      // Random phase against the reference model
      for (int i = 0; i < 4000; i++) begin
         bit          we, tk;
         logic [2:0]  a;
         logic [15:0] wd;
         if (i % 500 == 250) begin
            step(1'b1, 3'd5, {1'b0, m_day}, 1'b0);
            step(1'b1, 3'd4, {7'h0, m_hi}, 1'b0);
            step(1'b1, 3'd3, {8'h0, m_lo + 8'd4}, 1'b0);
         end
         we = ($urandom % 8) == 0;
         tk = ($urandom % 3) == 0;
         a  = 3'($urandom % 8);
         wd = 16'($urandom);
         step(we, a, wd, tk);
         check("R2 random read vs model", int'(reg_rdata), int'(exp_reg(a)));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule